// File: doc/BRIEF.md
# GPIO and Control Register Block

This block is a small peripheral that sits on a simple synchronous register bus. It holds a set of 16-bit control registers: mode, clock divider, a read-only status word, power control, clock control, and three interrupt-related words (request, mask and status) that are only stored. It also holds a 16-line general-purpose I/O port with a direction register and a level register.

Software writes the level register through either of two aliased offsets. Each level write is masked by the direction register. External input lines can also load individual level bits. The output lines present the level bits that are configured as outputs. They change only when software writes the direction or the level. A change-pulse vector marks, for one cycle, every output line that toggled on that write.

A read strobe returns data on the cycle after the strobe. An access to an offset that is not defined returns zero, has no effect, and raises a one-cycle error flag.

Top module: `gpio_ctrl_regs`

## Requirements
- R1: The 6-bit byte address selects a register by exact match: 0x00 mode, 0x04 clock divider, 0x08 status, 0x0C power, 0x10 clock control, 0x14 interrupt request, 0x18 interrupt mask, 0x1C interrupt status, 0x20 direction, 0x24 level (write port), 0x28 level (read port). Every other value is undefined.
- R2: A write to mode, clock divider, clock control or any of the three interrupt words stores the 16-bit write data, and a later read returns it. Read data appears on `bus_rdata` in the cycle after `bus_rd` is high, and is 0 in any cycle that does not follow a read.
- R3: A write to the power register stores the written value. When bit 7 of that value is 1, bits 15 and 6 are also stored as 1, which means the value is ORed with 0x8040.
- R4: The status register reads 0x0002 at all times. Writes to offset 0x08 change nothing.
- R5: A write to 0x24 or to 0x28 stores the write data ANDed with the current direction register into the level register. A read of either offset returns the level register.
- R6: When `gpio_in_we[i]` is 1, bit i of the level register takes `gpio_in[i]`. The outputs and change pulses do not move because of this. If a bus level write happens in the same cycle, the bus write decides the whole level register.
- R7: On each write to the direction register or to either level offset, `gpio_out` becomes level AND direction, using the values as they stand after that clock edge. In the same cycle, `gpio_chg` shows for one cycle the bits that differ from the previous `gpio_out`. At all other times `gpio_chg` is 0 and `gpio_out` holds its value.
- R8: A read of an undefined offset returns 0. A write to an undefined offset changes no register. Either access raises `bus_err` for one cycle, in the cycle after the strobe.
- R9: After reset, every register reads 0 except status. `gpio_out`, `gpio_chg`, `bus_rdata` and `bus_err` are all 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte offset of the access |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, one cycle after the read strobe |
| bus_err | output | 1 | One-cycle flag for an access to an undefined offset |
| gpio_in | input | GPIO_W | External level values |
| gpio_in_we | input | GPIO_W | Per-line load enables for gpio_in |
| gpio_out | output | GPIO_W | Level AND direction, updated on direction or level writes |
| gpio_chg | output | GPIO_W | One-cycle mask of output lines that toggled |

## Verification
The bench builds the block with its default widths: 16 GPIO lines and 16-bit registers. This keeps the full 64-offset address space small enough to sweep exhaustively. After reset it reads every offset. It then writes a distinct pattern to each of the 64 offsets in turn, and after each write reads back all 64 offsets against an arithmetic model. That covers every decode hole, the status and power rules, and the masking and output re-evaluation from each direction and level write. Targeted sequences add the power trigger bit in both states, loads from the input lines, and a bus level write that collides with input loads.

// File: rtl/gcr_pkg.sv
package gcr_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFF_MODE = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_CDIV = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_STAT = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_PWR  = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_CCTL = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_IREQ = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_IMSK = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_ISTS = 6'h1C;
  localparam logic [ADDR_W-1:0] OFF_DIR  = 6'h20;
  localparam logic [ADDR_W-1:0] OFF_LVLW = 6'h24;
  localparam logic [ADDR_W-1:0] OFF_LVLR = 6'h28;

  localparam logic [REG_W-1:0] STATUS_RST   = 16'h0002;
  localparam int               PWR_TRIG_BIT = 7;
  localparam logic [REG_W-1:0] PWR_SET_MASK = 16'h8040;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_MODE, SEL_CDIV, SEL_STAT, SEL_PWR, SEL_CCTL,
    SEL_IREQ, SEL_IMSK, SEL_ISTS, SEL_DIR, SEL_LVLW, SEL_LVLR
  } sel_e;

  // plain store-and-return registers, indexed 0..NPLAIN-1
  localparam int NPLAIN = 6;

  function automatic sel_e plain_sel(int idx);
    case (idx)
      0:       return SEL_MODE;
      1:       return SEL_CDIV;
      2:       return SEL_CCTL;
      3:       return SEL_IREQ;
      4:       return SEL_IMSK;
      default: return SEL_ISTS;
    endcase
  endfunction
endpackage

// File: rtl/gcr_decode.sv
module gcr_decode
  import gcr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel
);
  always_comb begin
    case (addr)
      OFF_MODE: sel = SEL_MODE;
      OFF_CDIV: sel = SEL_CDIV;
      OFF_STAT: sel = SEL_STAT;
      OFF_PWR:  sel = SEL_PWR;
      OFF_CCTL: sel = SEL_CCTL;
      OFF_IREQ: sel = SEL_IREQ;
      OFF_IMSK: sel = SEL_IMSK;
      OFF_ISTS: sel = SEL_ISTS;
      OFF_DIR:  sel = SEL_DIR;
      OFF_LVLW: sel = SEL_LVLW;
      OFF_LVLR: sel = SEL_LVLR;
      default:  sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/gcr_regfile.sv
module gcr_regfile
  import gcr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  sel_e                 sel,
  input  logic [REG_W-1:0]     wdata,
  output logic [NPLAIN-1:0][REG_W-1:0] plain_q,
  output logic [REG_W-1:0]     pwr_q
);
  genvar gi;
  generate
    for (gi = 0; gi < NPLAIN; gi++) begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)
          plain_q[gi] <= '0;
        else if (wr && sel == plain_sel(gi))
          plain_q[gi] <= wdata;
      end
    end
  endgenerate

  logic pwr_wr;
  assign pwr_wr = wr && sel == SEL_PWR;

  always_ff @(posedge clk) begin
    if (rst)
      pwr_q <= '0;
    else if (pwr_wr)
      pwr_q <= wdata[PWR_TRIG_BIT] ? (wdata | PWR_SET_MASK) : wdata;
  end

  assert_pwr_force_R3: assert property (@(posedge clk) disable iff (rst)
    $past(pwr_wr && wdata[PWR_TRIG_BIT]) |-> ((pwr_q & PWR_SET_MASK) == PWR_SET_MASK));

  assert_pwr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(pwr_wr) |-> $stable(pwr_q));
endmodule

// File: rtl/gcr_gpio.sv
module gcr_gpio
  import gcr_pkg::*;
#(
  parameter int GPIO_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  sel_e              sel,
  input  logic [GPIO_W-1:0] wdata,
  input  logic [GPIO_W-1:0] in_val,
  input  logic [GPIO_W-1:0] in_we,
  output logic [GPIO_W-1:0] dir_q,
  output logic [GPIO_W-1:0] lvl_q,
  output logic [GPIO_W-1:0] out_q,
  output logic [GPIO_W-1:0] chg_q
);
  logic              dir_wr, lvl_wr, eval;
  logic [GPIO_W-1:0] dir_nx, lvl_nx, eff_nx;

  assign dir_wr = wr && sel == SEL_DIR;
  assign lvl_wr = wr && (sel == SEL_LVLW || sel == SEL_LVLR);
  assign eval   = dir_wr || lvl_wr;
  assign dir_nx = dir_wr ? wdata : dir_q;

  genvar gi;
  generate
    for (gi = 0; gi < GPIO_W; gi++) begin : g_line
      always_comb begin
        if (lvl_wr)
          lvl_nx[gi] = wdata[gi] & dir_q[gi];
        else if (in_we[gi])
          lvl_nx[gi] = in_val[gi];
        else
          lvl_nx[gi] = lvl_q[gi];
      end
    end
  endgenerate

  assign eff_nx = lvl_nx & dir_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      lvl_q <= '0;
      out_q <= '0;
      chg_q <= '0;
    end else begin
      dir_q <= dir_nx;
      lvl_q <= lvl_nx;
      if (eval) begin
        out_q <= eff_nx;
        chg_q <= eff_nx ^ out_q;
      end else begin
        chg_q <= '0;
      end
    end
  end

  assert_lvl_masked_R5: assert property (@(posedge clk) disable iff (rst)
    $past(lvl_wr) |-> ((lvl_q & ~dir_q) == '0));

  assert_in_no_out_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(eval) |-> ($stable(out_q) && chg_q == '0));

  assert_out_gated_R7: assert property (@(posedge clk) disable iff (rst)
    (out_q & ~dir_q) == '0);

  assert_chg_tracks_R7: assert property (@(posedge clk) disable iff (rst)
    $past(eval) |-> (chg_q == (out_q ^ $past(out_q))));
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gcr_pkg::*;
#(
  parameter int GPIO_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              bus_err,
  input  logic [GPIO_W-1:0] gpio_in,
  input  logic [GPIO_W-1:0] gpio_in_we,
  output logic [GPIO_W-1:0] gpio_out,
  output logic [GPIO_W-1:0] gpio_chg
);
  localparam int PAD_W = REG_W - GPIO_W;

  sel_e                        sel;
  logic [NPLAIN-1:0][REG_W-1:0] plain_q;
  logic [REG_W-1:0]            pwr_q;
  logic [GPIO_W-1:0]           dir_q, lvl_q;
  logic [REG_W-1:0]            rd_val;

  gcr_decode u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  gcr_regfile u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr      (bus_wr),
    .sel     (sel),
    .wdata   (bus_wdata),
    .plain_q (plain_q),
    .pwr_q   (pwr_q)
  );

  gcr_gpio #(.GPIO_W(GPIO_W)) u_gpio (
    .clk    (clk),
    .rst    (rst),
    .wr     (bus_wr),
    .sel    (sel),
    .wdata  (bus_wdata[GPIO_W-1:0]),
    .in_val (gpio_in),
    .in_we  (gpio_in_we),
    .dir_q  (dir_q),
    .lvl_q  (lvl_q),
    .out_q  (gpio_out),
    .chg_q  (gpio_chg)
  );

  function automatic logic [REG_W-1:0] widen(logic [GPIO_W-1:0] v);
    logic [REG_W-1:0] r;
    r = '0;
    r[GPIO_W-1:0] = v;
    return r;
  endfunction

  always_comb begin
    case (sel)
      SEL_MODE: rd_val = plain_q[0];
      SEL_CDIV: rd_val = plain_q[1];
      SEL_CCTL: rd_val = plain_q[2];
      SEL_IREQ: rd_val = plain_q[3];
      SEL_IMSK: rd_val = plain_q[4];
      SEL_ISTS: rd_val = plain_q[5];
      SEL_STAT: rd_val = STATUS_RST;
      SEL_PWR:  rd_val = pwr_q;
      SEL_DIR:  rd_val = widen(dir_q);
      SEL_LVLW, SEL_LVLR: rd_val = widen(lvl_q);
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= bus_rd ? rd_val : '0;
      bus_err   <= (bus_rd || bus_wr) && sel == SEL_NONE;
    end
  end

  if (PAD_W < 0) begin : g_bad_width
    initial $display("GPIO_W must not exceed the register width");
  end

  assert_idle_rdata_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> bus_rdata == '0);

  assert_status_read_R4: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && bus_addr == OFF_STAT) |-> bus_rdata == STATUS_RST);

  assert_err_needs_access_R8: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(bus_rd || bus_wr));

  assert_undef_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> bus_rdata == '0);
endmodule

// File: tb/tb_gpio_ctrl_regs.sv
module tb_gpio_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_rdata;
  logic        bus_err;
  logic [15:0] gpio_in = '0, gpio_in_we = '0;
  logic [15:0] gpio_out, gpio_chg;

  int n_chk = 0, n_bad = 0;

  // bench model
  logic [15:0] m_mode, m_cdiv, m_pwr, m_cctl, m_ireq, m_imsk, m_ists;
  logic [15:0] m_dir, m_lvl, m_out, m_chg;

  always #4 clk = ~clk;

  gpio_ctrl_regs dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .gpio_in(gpio_in), .gpio_in_we(gpio_in_we), .gpio_out(gpio_out), .gpio_chg(gpio_chg)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit undef(int off);
    case (off)
      8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C,
      8'h20, 8'h24, 8'h28: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [15:0] exp_rd(int off);
    case (off)
      8'h00: return m_mode;
      8'h04: return m_cdiv;
      8'h08: return 16'h0002;
      8'h0C: return m_pwr;
      8'h10: return m_cctl;
      8'h14: return m_ireq;
      8'h18: return m_imsk;
      8'h1C: return m_ists;
      8'h20: return m_dir;
      8'h24, 8'h28: return m_lvl;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic model_reeval();
    logic [15:0] e;
    e = m_lvl & m_dir;
    m_chg = e ^ m_out;
    m_out = e;
  endtask

  task automatic model_write(int off, logic [15:0] d);
    m_chg = '0;
    case (off)
      8'h00: m_mode = d;
      8'h04: m_cdiv = d;
      8'h0C: m_pwr  = d[7] ? (d | 16'h8040) : d;
      8'h10: m_cctl = d;
      8'h14: m_ireq = d;
      8'h18: m_imsk = d;
      8'h1C: m_ists = d;
      8'h20: begin m_dir = d; model_reeval(); end
      8'h24, 8'h28: begin m_lvl = d & m_dir; model_reeval(); end
      default: ;
    endcase
  endtask

  // strobes are driven at a negedge; results are sampled at the next negedge
  task automatic bus_write(int off, logic [15:0] d);
    bus_addr = 6'(off); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    model_write(off, d);
    check(undef(off) ? "R8 write err" : "R1 write err", {15'b0, bus_err}, {15'b0, undef(off)});
    check("R7 gpio_out", gpio_out, m_out);
    check("R7 gpio_chg", gpio_chg, m_chg);
  endtask

  task automatic bus_read(int off, string req);
    bus_addr = 6'(off); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, bus_rdata, exp_rd(off));
    check(undef(off) ? "R8 read err" : "R1 read err", {15'b0, bus_err}, {15'b0, undef(off)});
  endtask

  task automatic read_all(string req);
    for (int o = 0; o < 64; o++) bus_read(o, req);
  endtask

  initial begin
    #(8 * 190000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_mode = 0; m_cdiv = 0; m_pwr = 0; m_cctl = 0; m_ireq = 0; m_imsk = 0;
    m_ists = 0; m_dir = 0; m_lvl = 0; m_out = 0; m_chg = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9: reset state
    check("R9 gpio_out", gpio_out, 16'h0);
    check("R9 gpio_chg", gpio_chg, 16'h0);
    check("R9 rdata", bus_rdata, 16'h0);
    check("R9 err", {15'b0, bus_err}, 16'h0);
    read_all("R9 reset read");

    // R1 R2 R4 R5 R7 R8: write each offset, then read everything
    for (int o = 0; o < 64; o++) begin
      logic [15:0] d;
      d = 16'(o * 16'h3B1D) ^ 16'h6C5A;
      bus_write(o, d);
      read_all("R2 sweep read");
    end

    // R3: trigger bit clear and set
    bus_write(8'h0C, 16'h0001);
    bus_read(8'h0C, "R3 no trigger");
    bus_write(8'h0C, 16'h0080);
    bus_read(8'h0C, "R3 trigger sets 15 and 6");
    check("R3 literal", m_pwr, 16'h80C0);

    // R4: status write ignored
    bus_write(8'h08, 16'hFFFF);
    bus_read(8'h08, "R4 status");

    // R5 R7: direction then level through both offsets
    bus_write(8'h20, 16'h00FF);
    bus_write(8'h24, 16'hFFFF);
    check("R5 literal", m_lvl, 16'h00FF);
    bus_read(8'h28, "R5 alias read");
    bus_write(8'h28, 16'h0F0F);
    bus_read(8'h24, "R5 alias read");
    bus_write(8'h20, 16'hFF00);
    bus_write(8'h20, 16'h0FF0);

    // R6: input loads touch level only
    bus_write(8'h20, 16'hFFFF);
    gpio_in = 16'hA5A5; gpio_in_we = 16'hFFFF;
    @(negedge clk);
    gpio_in_we = '0;
    m_lvl = 16'hA5A5;
    check("R6 out unchanged", gpio_out, m_out);
    check("R6 chg quiet", gpio_chg, 16'h0);
    bus_read(8'h24, "R6 level loaded");
    gpio_in = 16'h0000; gpio_in_we = 16'h00F0;
    @(negedge clk);
    gpio_in_we = '0;
    m_lvl = m_lvl & 16'hFF0F;
    check("R6 out unchanged", gpio_out, m_out);
    bus_read(8'h28, "R6 partial load");
    bus_write(8'h20, 16'hFFFF);  // re-evaluates from loaded level

    // R6: bus level write wins over input loads in the same cycle
    gpio_in = 16'hFFFF; gpio_in_we = 16'hFFFF;
    bus_write(8'h24, 16'h1234);
    gpio_in_we = '0;
    bus_read(8'h24, "R6 bus wins");

    // R8: undefined writes change nothing
    bus_write(8'h2C, 16'hFFFF);
    bus_write(8'h01, 16'hFFFF);
    bus_write(8'h3F, 16'hFFFF);
    read_all("R8 after undefined writes");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule